// File: doc/BRIEF.md
# Configurable PLD Macrocell

This block is one logic cell of a sum-of-products programmable array. It receives a global bus and a regional bus and forms five product terms from them. Each term is an AND over any chosen set of bus signals, in true or complemented form. A static configuration word decides how those five terms are used. They can feed an OR sum that is chained with a neighbouring cell, feed an XOR polarity stage, feed a storage element, or drive that element's clock, clock enable, reset and preset. One term can also drive the output enable of the pin.

The cell drives a pin value with an output enable, a buried feedback signal for the global bus, an inverted foldback term for the regional bus, and a cascade output for the next cell. The storage element can act as a D, T, JK or SR flip-flop, or as a level-sensitive latch.

Every pin-level clock, clear and enable is sampled on the system clock `clk`. An "edge" of a selected clock means that it reads 1 on one `clk` edge after reading 0 on the previous one. A control that takes effect at a `clk` edge is visible on the outputs right after that edge.

Top module: `pld_macrocell`

## Requirements
- R1: Product term i is 1 when every bus bit `a = {rbus_i, gbus_i}` selected by `pt_true_i[i*AW+b]` is 1 and every bit selected by `pt_comp_i[i*AW+b]` is 0. A term with no bits selected is 1. A 3-bit term index of 0..4 picks that term, and an index of 5..7 reads as constant 0.
- R2: The OR sum is the OR of the terms whose bit is set in `sum_en` together with `cas_i`, and `cas_o` equals that sum.
- R3: The combinational value is the OR sum XOR a second input. `xin_mode` selects that input: 0 and 3 give constant 0, 1 gives constant 1, and 2 gives the term at `xin_idx`.
- R4: The storage data input is the combinational value when `d_src`=0, or the term at `d_idx` when `d_src`=1.
- R5: On a clock event, kind D (0) loads the data input, and kind T (1) inverts the state when the data input is 1.
- R6: On a clock event, kind JK (2) uses the data input as J and the term at `k_idx` as K. It holds on 00, sets on 10, clears on 01 and toggles on 11. Kind SR (3) uses the data input as S and the same term as R: S alone sets, R alone clears, and 00 or 11 holds. Kind values 5..7 act as D.
- R7: Kind LATCH (4) loads the data input at every `clk` edge while the selected clock is 1, and holds while it is 0.
- R8: The selected clock is `gclk_i` when `clk_src`=0, or the term at `clk_idx` when `clk_src`=1. An event is a 0-to-1 change between consecutive `clk` edges. Only with `clk_src`=0 and `ce_en`=1 does the term at `ce_idx` act as an enable, and it blocks events and latch loads while it is 0. Without an event the state holds.
- R9: The reset source is set by `ar_mode`: 0 is `gclr_n_i` low, 1 is the term at `ar_idx`, 2 is never, and 3 is the OR of the first two. When `ap_en`=1 the term at `ap_idx` presets the state to 1. Reset overrides preset, and both override clocking.
- R10: When `out_comb`=0, `pin_o` and `fb_o` carry the state. When `out_comb`=1, `pin_o` carries the combinational value, and `fb_o` carries the state if `d_src`=1 or the combinational value otherwise.
- R11: `oe_mode` sets `pin_oe_o`: 0 is 1, 1 is 0, 2 is `oe1_i`, 3 is the inverse of `oe2_n_i`, 4 is the term at `oe_idx`, and 5..7 are 0. It has no effect on `fb_o`, `cas_o` or `fold_o`.
- R12: `fold_o` is the inverse of the term at `fold_idx`.
- R13: While `rst_n` is low at a `clk` edge, the state becomes 0 and the clock history reads 1. After reset, a clock that is already high therefore gives no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock on which all pin-level controls are sampled |
| rst_n | input | 1 | Synchronous active-low reset (power-up clear) |
| cfg_i | input | CFG_W | Static mode word (`mcell_cfg_t`) |
| pt_true_i | input | NPT*AW | True-polarity selection mask per product term |
| pt_comp_i | input | NPT*AW | Complement-polarity selection mask per product term |
| gbus_i | input | GW | Global bus signals |
| rbus_i | input | RW | Regional bus signals |
| gclk_i | input | 1 | Global clock pin level |
| gclr_n_i | input | 1 | Global clear pin, active low |
| oe1_i | input | 1 | Output enable pin 1, active high |
| oe2_n_i | input | 1 | Output enable pin 2, active low |
| cas_i | input | 1 | Cascade input from the neighbouring cell |
| pin_o | output | 1 | Pin data value |
| pin_oe_o | output | 1 | Pin output enable |
| fb_o | output | 1 | Buried feedback to the global bus |
| fold_o | output | 1 | Inverted foldback term to the regional bus |
| cas_o | output | 1 | Cascade output (OR sum) |

## Verification
The bench sweeps every combination of storage kind, clock source, reset mode, output-enable mode, output select and data source. Within each combination it drives random term masks, indices and pin activity, and it compares every output each cycle against an arithmetic model. It goes after reset and preset asserted together, where a design that let preset win would show a 1. It also goes after a term index of 5..7, which a design that wrapped the index would read as a live term. A clock enable applied under a term clock would wrongly freeze the state. A clock held high through reset would be taken as an edge if the edge history started at 0. Feedback in combinational mode with a dedicated data term is also covered, since a design that got it wrong would return the combinational value instead of the register.

// File: rtl/mcell_pkg.sv
// Shared constants, mode encodings and the configuration word of the macrocell.
// Assumes at most eight product terms so that a 3-bit index covers them.
package mcell_pkg;

    localparam int NPT   = 5;
    localparam int IDX_W = 3;

    typedef enum logic [1:0] {XIN_ZERO = 2'd0, XIN_ONE = 2'd1, XIN_TERM = 2'd2} xin_e;
    typedef enum logic [2:0] {ST_D = 3'd0, ST_T = 3'd1, ST_JK = 3'd2, ST_SR = 3'd3,
                              ST_LATCH = 3'd4} store_e;
    typedef enum logic [1:0] {AR_PIN = 2'd0, AR_TERM = 2'd1, AR_NONE = 2'd2,
                              AR_BOTH = 2'd3} ar_e;
    typedef enum logic [2:0] {OE_ON = 3'd0, OE_OFF = 3'd1, OE_PIN1 = 3'd2,
                              OE_PIN2N = 3'd3, OE_TERM = 3'd4} oe_e;

    typedef struct packed {
        logic [NPT-1:0]   sum_en;
        xin_e             xin_mode;
        logic [IDX_W-1:0] xin_idx;
        logic             d_src;
        logic [IDX_W-1:0] d_idx;
        store_e           ff_kind;
        logic [IDX_W-1:0] k_idx;
        logic             clk_src;
        logic [IDX_W-1:0] clk_idx;
        logic             ce_en;
        logic [IDX_W-1:0] ce_idx;
        ar_e              ar_mode;
        logic [IDX_W-1:0] ar_idx;
        logic             ap_en;
        logic [IDX_W-1:0] ap_idx;
        logic             out_comb;
        oe_e              oe_mode;
        logic [IDX_W-1:0] oe_idx;
        logic [IDX_W-1:0] fold_idx;
    } mcell_cfg_t;

    localparam int CFG_W = $bits(mcell_cfg_t);

    // Returns the indexed term, or 0 for an index past the last term.
    function automatic logic pick(input logic [NPT-1:0] t, input logic [IDX_W-1:0] idx);
        logic [(2**IDX_W)-1:0] ext;
        ext          = '0;
        ext[NPT-1:0] = t;
        return ext[idx];
    endfunction

endpackage

// File: rtl/mcell_pterms.sv
// Product-term array: each term ANDs the bus bits chosen by its true and
// complement masks. Assumes masks are static; an empty mask yields 1.
module mcell_pterms #(
    parameter int AW  = 8,
    parameter int NT  = 5
) (
    input  logic [AW-1:0]    a_i,
    input  logic [NT*AW-1:0] tmask_i,
    input  logic [NT*AW-1:0] cmask_i,
    output logic [NT-1:0]    pt_o
);
    for (genvar i = 0; i < NT; i++) begin : g_term
        logic [AW-1:0] tm, cm;
        assign tm = tmask_i[i*AW +: AW];
        assign cm = cmask_i[i*AW +: AW];
        // One AND per term over the selected true and complemented inputs
        assign pt_o[i] = (&(a_i | ~tm)) & (&(~a_i | ~cm));
    end
endmodule

// File: rtl/mcell_sumxor.sv
// OR sum with cascade chaining followed by the XOR polarity stage.
// Assumes the mode inputs are static; clk and rst_n only qualify assertions.
module mcell_sumxor
    import mcell_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPT-1:0]      pt_i,
    input  logic [NPT-1:0]      sum_en_i,
    input  logic                cas_i,
    input  xin_e                xin_mode_i,
    input  logic [IDX_W-1:0]    xin_idx_i,
    output logic                sum_o,
    output logic                comb_o
);
    logic xin;

    // Choose the second XOR input: constant or a product term
    always_comb begin
        case (xin_mode_i)
            XIN_ONE:  xin = 1'b1;
            XIN_TERM: xin = pick(pt_i, xin_idx_i);
            default:  xin = 1'b0;
        endcase
    end

    assign sum_o  = (|(pt_i & sum_en_i)) | cas_i;
    assign comb_o = sum_o ^ xin;

    // R2
    cascade_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cas_i |-> sum_o);
    // R2
    empty_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_en_i == '0 && !cas_i) |-> !sum_o);
endmodule

// File: rtl/mcell_store.sv
// Configurable storage element: D, T, JK, SR flip-flop or level latch.
// Assumes a sampled clock level; events are 0-to-1 changes between clk edges.
// Reset beats preset, and both beat clocking.
module mcell_store
    import mcell_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  store_e kind_i,
    input  logic   d_i,
    input  logic   k_i,
    input  logic   lvl_i,
    input  logic   ce_i,
    input  logic   ar_i,
    input  logic   ap_i,
    output logic   q_o
);
    logic prev;
    logic nxt;

    // Next state for an edge event according to the storage kind
    always_comb begin
        case (kind_i)
            ST_T:    nxt = q_o ^ d_i;
            ST_JK:   nxt = (d_i & ~q_o) | (~k_i & q_o);
            ST_SR:   nxt = (d_i & ~k_i) | (q_o & ~(k_i & ~d_i));
            default: nxt = d_i;
        endcase
    end

    // State and clock history update with reset/preset priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o  <= 1'b0;
            prev <= 1'b1;
        end else begin
            prev <= lvl_i;
            if (ar_i) begin
                q_o <= 1'b0;
            end else if (ap_i) begin
                q_o <= 1'b1;
            end else if (ce_i) begin
                if (kind_i == ST_LATCH) begin
                    if (lvl_i) q_o <= d_i;
                end else if (lvl_i && !prev) begin
                    q_o <= nxt;
                end
            end
        end
    end

    // R9
    ar_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ar_i |=> !q_o);
    // R9
    preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_i && !ar_i) |=> q_o);
    // R8
    no_enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ar_i && !ap_i && !ce_i) |=> $stable(q_o));
    // R13
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!q_o && prev));
endmodule

// File: rtl/pld_macrocell.sv
// Top of one programmable logic cell. Builds the product terms, routes them
// to the sum/XOR stage, storage controls, output enable and foldback, and
// selects the pin and feedback values. Assumes cfg_i and the masks are static.
module pld_macrocell
    import mcell_pkg::*;
#(
    parameter int GW = 32,
    parameter int RW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CFG_W-1:0]     cfg_i,
    input  logic [NPT*(GW+RW)-1:0] pt_true_i,
    input  logic [NPT*(GW+RW)-1:0] pt_comp_i,
    input  logic [GW-1:0]        gbus_i,
    input  logic [RW-1:0]        rbus_i,
    input  logic                 gclk_i,
    input  logic                 gclr_n_i,
    input  logic                 oe1_i,
    input  logic                 oe2_n_i,
    input  logic                 cas_i,
    output logic                 pin_o,
    output logic                 pin_oe_o,
    output logic                 fb_o,
    output logic                 fold_o,
    output logic                 cas_o
);
    localparam int AW = GW + RW;

    mcell_cfg_t     cfg;
    logic [NPT-1:0] pt;
    logic           sum, comb, d, k, lvl, ce, ar, ap, q;

    assign cfg = mcell_cfg_t'(cfg_i);

    mcell_pterms #(.AW(AW), .NT(NPT)) u_terms (
        .a_i     ({rbus_i, gbus_i}),
        .tmask_i (pt_true_i),
        .cmask_i (pt_comp_i),
        .pt_o    (pt)
    );

    mcell_sumxor u_sum (
        .clk        (clk),
        .rst_n      (rst_n),
        .pt_i       (pt),
        .sum_en_i   (cfg.sum_en),
        .cas_i      (cas_i),
        .xin_mode_i (cfg.xin_mode),
        .xin_idx_i  (cfg.xin_idx),
        .sum_o      (sum),
        .comb_o     (comb)
    );

    // Storage data, second input, clock level and clock enable
    always_comb begin
        d   = cfg.d_src ? pick(pt, cfg.d_idx) : comb;
        k   = pick(pt, cfg.k_idx);
        lvl = cfg.clk_src ? pick(pt, cfg.clk_idx) : gclk_i;
        ce  = (!cfg.clk_src && cfg.ce_en) ? pick(pt, cfg.ce_idx) : 1'b1;
    end

    // Asynchronous-style reset and preset source selection
    always_comb begin
        case (cfg.ar_mode)
            AR_PIN:  ar = !gclr_n_i;
            AR_TERM: ar = pick(pt, cfg.ar_idx);
            AR_BOTH: ar = !gclr_n_i || pick(pt, cfg.ar_idx);
            default: ar = 1'b0;
        endcase
        ap = cfg.ap_en && pick(pt, cfg.ap_idx);
    end

    mcell_store u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .kind_i (cfg.ff_kind),
        .d_i    (d),
        .k_i    (k),
        .lvl_i  (lvl),
        .ce_i   (ce),
        .ar_i   (ar),
        .ap_i   (ap),
        .q_o    (q)
    );

    // Output enable source selection
    always_comb begin
        case (cfg.oe_mode)
            OE_ON:    pin_oe_o = 1'b1;
            OE_PIN1:  pin_oe_o = oe1_i;
            OE_PIN2N: pin_oe_o = !oe2_n_i;
            OE_TERM:  pin_oe_o = pick(pt, cfg.oe_idx);
            default:  pin_oe_o = 1'b0;
        endcase
    end

    // Pin value, buried feedback, foldback and cascade outputs
    always_comb begin
        pin_o  = cfg.out_comb ? comb : q;
        fb_o   = (cfg.out_comb && !cfg.d_src) ? comb : q;
        fold_o = !pick(pt, cfg.fold_idx);
        cas_o  = sum;
    end
endmodule

// File: tb/tb_pld_macrocell.sv
// Sweeps all mode combinations with random masks and pin activity and
// compares every output each cycle with an arithmetic model.
module tb_pld_macrocell;
    import mcell_pkg::*;

    localparam int GW = 3;
    localparam int RW = 1;
    localparam int AW = GW + RW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    mcell_cfg_t cfg;
    logic [NPT*AW-1:0] tmask, cmask;
    logic [GW-1:0] gbus;
    logic [RW-1:0] rbus;
    logic gclk, gclr_n, oe1, oe2_n, cas;
    logic pin_o, pin_oe_o, fb_o, fold_o, cas_o;

    pld_macrocell #(.GW(GW), .RW(RW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .pt_true_i(tmask), .pt_comp_i(cmask),
        .gbus_i(gbus), .rbus_i(rbus), .gclk_i(gclk), .gclr_n_i(gclr_n),
        .oe1_i(oe1), .oe2_n_i(oe2_n), .cas_i(cas),
        .pin_o(pin_o), .pin_oe_o(pin_oe_o), .fb_o(fb_o), .fold_o(fold_o), .cas_o(cas_o)
    );

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;
    bit q_m     = 0;
    bit prev_m  = 1;
    string tag_m = "R13";

    function automatic bit mpt(int i);
        logic [AW-1:0] a = {rbus, gbus};
        bit t = 1;
        for (int b = 0; b < AW; b++) begin
            if (tmask[i*AW+b] && !a[b]) t = 0;
            if (cmask[i*AW+b] && a[b])  t = 0;
        end
        return t;
    endfunction

    function automatic bit msel(logic [2:0] idx);
        return (idx < 5) ? mpt(int'(idx)) : 1'b0;
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: got %b expected %b (cfg %h) at %0t", tag, act, exp, cfg, $time);
        end
    endtask

    task automatic run_vec(bit in_reset);
        bit sum, xin, comb, d, k, lvl, ce, ar, ap, oe_e, pin_e, fb_e, nq;
        rst_n  = !in_reset;
        gbus   = GW'($urandom);
        rbus   = RW'($urandom);
        gclk   = 1'($urandom);
        gclr_n = ($urandom_range(0, 7) != 0);
        oe1    = 1'($urandom);
        oe2_n  = 1'($urandom);
        cas    = ($urandom_range(0, 3) == 0);
        #1;
        sum = cas;
        for (int i = 0; i < NPT; i++) if (cfg.sum_en[i] && mpt(i)) sum = 1;
        xin  = (cfg.xin_mode == 2'd1) ? 1'b1 : (cfg.xin_mode == 2'd2) ? msel(cfg.xin_idx) : 1'b0;
        comb = sum ^ xin;
        d    = cfg.d_src ? msel(cfg.d_idx) : comb;
        k    = msel(cfg.k_idx);
        lvl  = cfg.clk_src ? msel(cfg.clk_idx) : gclk;
        ce   = (!cfg.clk_src && cfg.ce_en) ? msel(cfg.ce_idx) : 1'b1;
        case (int'(cfg.ar_mode))
            0: ar = !gclr_n;
            1: ar = msel(cfg.ar_idx);
            3: ar = !gclr_n || msel(cfg.ar_idx);
            default: ar = 0;
        endcase
        ap = cfg.ap_en && msel(cfg.ap_idx);
        case (int'(cfg.oe_mode))
            0: oe_e = 1;
            2: oe_e = oe1;
            3: oe_e = !oe2_n;
            4: oe_e = msel(cfg.oe_idx);
            default: oe_e = 0;
        endcase
        pin_e = cfg.out_comb ? comb : q_m;
        fb_e  = (cfg.out_comb && !cfg.d_src) ? comb : q_m;
        chk("R2 cas_o", cas_o, sum);
        chk("R1/R12 fold_o", fold_o, !msel(cfg.fold_idx));
        chk("R11 pin_oe_o", pin_oe_o, oe_e);
        chk(cfg.out_comb ? "R3 pin_o" : $sformatf("%s/R10 pin_o", tag_m), pin_o, pin_e);
        chk(cfg.out_comb ? "R4/R10 fb_o" : $sformatf("%s/R10 fb_o", tag_m), fb_o, fb_e);
        @(posedge clk);
        if (in_reset) begin
            q_m = 0; prev_m = 1; tag_m = "R13";
        end else begin
            if (ar) begin
                q_m = 0; tag_m = "R9";
            end else if (ap) begin
                q_m = 1; tag_m = "R9";
            end else if (ce && int'(cfg.ff_kind) == 4) begin
                if (lvl) q_m = d;
                tag_m = "R7";
            end else if (ce && lvl && !prev_m) begin
                case (int'(cfg.ff_kind))
                    1: nq = q_m ^ d;
                    2: nq = (d && k) ? !q_m : d ? 1'b1 : k ? 1'b0 : q_m;
                    3: nq = (d && !k) ? 1'b1 : (k && !d) ? 1'b0 : q_m;
                    default: nq = d;
                endcase
                q_m = nq;
                tag_m = (int'(cfg.ff_kind) == 2 || int'(cfg.ff_kind) == 3) ? "R6/R8" : "R5/R8";
            end else begin
                tag_m = "R8";
            end
            prev_m = lvl;
        end
        #3;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        cfg = '0; tmask = '0; cmask = '0;
        gbus = '0; rbus = '0; gclk = 0; gclr_n = 1; oe1 = 0; oe2_n = 1; cas = 0;
        @(posedge clk);
        #3;
        for (int fk = 0; fk < 5; fk++)
        for (int cs = 0; cs < 2; cs++)
        for (int am = 0; am < 4; am++)
        for (int om = 0; om < 5; om++)
        for (int oc = 0; oc < 2; oc++)
        for (int ds = 0; ds < 2; ds++) begin
            cfg.ff_kind  = store_e'(fk);
            cfg.clk_src  = 1'(cs);
            cfg.ar_mode  = ar_e'(am);
            cfg.oe_mode  = oe_e'(om);
            cfg.out_comb = 1'(oc);
            cfg.d_src    = 1'(ds);
            cfg.sum_en   = NPT'($urandom);
            cfg.xin_mode = xin_e'($urandom_range(0, 3));
            cfg.xin_idx  = 3'($urandom_range(0, 5));
            cfg.d_idx    = 3'($urandom_range(0, 5));
            cfg.k_idx    = 3'($urandom_range(0, 5));
            cfg.clk_idx  = 3'($urandom_range(0, 5));
            cfg.ce_en    = 1'($urandom);
            cfg.ce_idx   = 3'($urandom_range(0, 5));
            cfg.ar_idx   = 3'($urandom_range(0, 5));
            cfg.ap_en    = 1'($urandom);
            cfg.ap_idx   = 3'($urandom_range(0, 5));
            cfg.oe_idx   = 3'($urandom_range(0, 5));
            cfg.fold_idx = 3'($urandom_range(0, 5));
            tmask = (NPT*AW)'($urandom & $urandom);
            cmask = (NPT*AW)'($urandom & $urandom) & ~tmask;
            for (int r = 0; r < 2; r++) run_vec(1'b1);
            for (int v = 0; v < 30; v++) run_vec(1'b0);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule